// File: doc/BRIEF.md
# Reloading Timer Bank

The block is a register-mapped timer peripheral on a plain 32-bit register bus. It holds three down-counting channels and one free-running up-counter. Two of the down-counters are 16 bits wide and the third is 32 bits wide. Each down-counter decrements once per qualifying tick. On underflow it either reloads from its load register (periodic mode) or wraps to all ones (free mode). Every underflow sets a level interrupt that stays high until software writes to that channel's clear register. The fourth channel is a 40-bit up-counter with an enable bit and no interrupt. Its low 32 bits sit in one register and its top 8 bits share a second register with the enable.

Clock generation is outside the block. Three single-cycle tick-enable inputs stand in for it. `slow_tick` is the main down-count rate, `alt_tick` is a slower alternative rate, and `fast_tick` drives the 40-bit counter. Reads are combinational from `bus_addr` while `bus_sel` is high. Writes take effect at the clock edge where `bus_sel` and `bus_wr` are both high.

Each down-counter is run by a two-state machine. `CH_STOPPED` moves to `CH_RUNNING` on a control write with bit 7 set, and moves back on a control write with bit 7 clear. The 40-bit counter has its own two states: `FR_HALTED` moves to `FR_COUNTING` on a write to its upper register with bit 8 set, and moves back when that bit is written clear.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset, every register reads zero, every channel is stopped and `irq` is 3'b000.
- R2: Down-channel k has four registers: load at base+0x0, current count at base+0x4, control at base+0x8 and clear at base+0xC. The bases are 0x00, 0x20 and 0x80 for k = 0, 1, 2. Channels 0 and 1 are 16 bits wide and channel 2 is 32 bits wide. Load writes keep only the low bits of the channel width, and reads are zero-extended.
- R3: A running channel decrements by one on each cycle in which its selected tick is high. A stopped channel holds its count.
- R4: In periodic mode (control bit 6 = 1), the tick that arrives at count zero reloads the load value. From a fresh load, this gives one underflow every load+1 ticks.
- R5: In free mode (control bit 6 = 0), the tick that arrives at count zero sets the count to all ones.
- R6: Underflow of channel k sets `irq[k]`. It stays high until any write to that channel's clear register. If an underflow and a clear fall in the same cycle, the underflow wins.
- R7: Control bit 3 = 1 selects `slow_tick` and bit 3 = 0 selects `alt_tick`. The tick that is not selected has no effect on the count.
- R8: A write to the load register sets the current count to the written value at once, whether the channel is running or stopped.
- R9: The control register reads back only bit 7 (running), bit 6 (periodic) and bit 3 (source); all other bits read as zero.
- R10: The 40-bit counter's bits 31:0 read at 0x60. Bits 39:32 read in bits 7:0 of 0x64, and bit 8 of 0x64 is its enable. When enabled it adds one on each `fast_tick`, and it holds its value when disabled. Writes to 0x60 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| slow_tick | input | 1 | Main down-count tick enable |
| alt_tick | input | 1 | Alternative slower tick enable |
| fast_tick | input | 1 | Tick enable of the 40-bit counter |
| irq | output | 3 | Level interrupt per down-channel |

## Verification
A channel whose state machine sits in the wrong state shows it straight away. The running bit in the control readback is wrong, and the count either moves or fails to move on the next selected tick. A wrong count or a lost load value becomes visible through the count register within one read. At the latest it shows at the next underflow, where the reload value or the wrap to all ones is read back in the same cycle that `irq` rises. An interrupt flag that is stuck or cleared too early appears on `irq` in the cycle after the clear write or the underflow tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned NUM_RELOAD = 3;
    localparam int unsigned ADDR_W     = 8;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned FREE_W     = 40;

    // control word bit positions (software-visible)
    localparam int unsigned CTL_RUN_BIT = 7;
    localparam int unsigned CTL_PER_BIT = 6;
    localparam int unsigned CTL_SRC_BIT = 3;
    // enable position in the upper free-counter register
    localparam int unsigned FREE_EN_BIT = 8;

    // register offsets inside a down-channel window
    localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h0;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h4;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h8;
    localparam logic [ADDR_W-1:0] OFS_CLEAR = 8'hC;

    localparam logic [ADDR_W-1:0] FREE_LO_ADDR = 8'h60;
    localparam logic [ADDR_W-1:0] FREE_HI_ADDR = 8'h64;

    typedef enum logic {
        CH_STOPPED = 1'b0,
        CH_RUNNING = 1'b1
    } ch_state_t;

    typedef enum logic {
        FR_HALTED   = 1'b0,
        FR_COUNTING = 1'b1
    } fr_state_t;

    function automatic logic [ADDR_W-1:0] chan_base(input int unsigned k);
        case (k)
            0:       chan_base = 8'h00;
            1:       chan_base = 8'h20;
            default: chan_base = 8'h80;
        endcase
    endfunction

    function automatic int unsigned chan_width(input int unsigned k);
        chan_width = (k == 2) ? 32 : 16;
    endfunction

endpackage

// File: rtl/tmr_reload_chan.sv
module tmr_reload_chan
    import tmr_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_wr,
    input  logic [WIDTH-1:0] ld_data,
    input  logic             ctl_wr,
    input  logic             ctl_run,
    input  logic             ctl_per,
    input  logic             ctl_src,
    input  logic             clr_wr,
    input  logic             slow_tick,
    input  logic             alt_tick,
    output logic [WIDTH-1:0] cnt_o,
    output logic [WIDTH-1:0] load_o,
    output logic [7:0]       ctrl_o,
    output logic             irq_o
);

    ch_state_t        state_q, state_d;
    logic             per_q, src_q;
    logic [WIDTH-1:0] cnt_q, load_q;
    logic             irq_q;
    logic             tick_sel, step, underflow;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_STOPPED;
        else        state_q <= state_d;
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOPPED: if (ctl_wr && ctl_run)  state_d = CH_RUNNING;
            CH_RUNNING: if (ctl_wr && !ctl_run) state_d = CH_STOPPED;
        endcase
    end

    assign tick_sel  = src_q ? slow_tick : alt_tick;
    assign step      = (state_q == CH_RUNNING) && tick_sel && !ld_wr;
    assign underflow = step && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q  <= 1'b0;
            src_q  <= 1'b0;
            load_q <= '0;
            cnt_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (ctl_wr) begin
                per_q <= ctl_per;
                src_q <= ctl_src;
            end
            if (ld_wr) begin
                load_q <= ld_data;
                cnt_q  <= ld_data;
            end else if (step) begin
                if (cnt_q == '0) cnt_q <= per_q ? load_q : '1;
                else             cnt_q <= cnt_q - WIDTH'(1);
            end
            if (underflow)   irq_q <= 1'b1;
            else if (clr_wr) irq_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        ctrl_o              = '0;
        ctrl_o[CTL_RUN_BIT] = (state_q == CH_RUNNING);
        ctrl_o[CTL_PER_BIT] = per_q;
        ctrl_o[CTL_SRC_BIT] = src_q;
        cnt_o               = cnt_q;
        load_o              = load_q;
        irq_o               = irq_q;
    end

    p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_STOPPED && !ld_wr) |=> $stable(cnt_q));

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && per_q && !ctl_wr) |=> (cnt_q == $past(load_q)));

    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !per_q && !ctl_wr) |=> (cnt_q == '1));

    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> irq_o);

    p_irq_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !underflow) |=> !irq_o);

    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wr |=> (cnt_o == $past(ld_data)));

endmodule

// File: rtl/tmr_freerun.sv
module tmr_freerun
    import tmr_pkg::*;
#(
    parameter int unsigned WIDTH = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             en_val,
    input  logic             fast_tick,
    output logic [WIDTH-1:0] cnt_o,
    output logic             en_o
);

    fr_state_t        state_q, state_d;
    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FR_HALTED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_HALTED:   if (en_wr && en_val)  state_d = FR_COUNTING;
            FR_COUNTING: if (en_wr && !en_val) state_d = FR_HALTED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                  cnt_q <= '0;
        else if (state_q == FR_COUNTING && fast_tick) cnt_q <= cnt_q + WIDTH'(1);
    end

    always_comb begin
        cnt_o = cnt_q;
        en_o  = (state_q == FR_COUNTING);
    end

    p_fr_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_o && fast_tick) |=> (cnt_o == $past(cnt_o) + WIDTH'(1)));

    p_fr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o || !fast_tick) |=> $stable(cnt_o));

endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
    import tmr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        slow_tick,
    input  logic        alt_tick,
    input  logic        fast_tick,
    output logic [2:0]  irq
);

    localparam int unsigned HI_W = FREE_W - DATA_W;

    logic [NUM_RELOAD-1:0][DATA_W-1:0] cnt_ext;
    logic [NUM_RELOAD-1:0][DATA_W-1:0] load_ext;
    logic [NUM_RELOAD-1:0][7:0]        ctrl_rd;
    logic [FREE_W-1:0]                 free_cnt;
    logic                              free_en;
    logic                              wr_stb;

    assign wr_stb = bus_sel && bus_wr;

    for (genvar i = 0; i < NUM_RELOAD; i++) begin : g_chan
        localparam int unsigned W = chan_width(i);
        localparam logic [ADDR_W-1:0] BASE = chan_base(i);
        logic [W-1:0] cnt_w, load_w;

        tmr_reload_chan #(.WIDTH(W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld_wr     (wr_stb && bus_addr == BASE + OFS_LOAD),
            .ld_data   (bus_wdata[W-1:0]),
            .ctl_wr    (wr_stb && bus_addr == BASE + OFS_CTRL),
            .ctl_run   (bus_wdata[CTL_RUN_BIT]),
            .ctl_per   (bus_wdata[CTL_PER_BIT]),
            .ctl_src   (bus_wdata[CTL_SRC_BIT]),
            .clr_wr    (wr_stb && bus_addr == BASE + OFS_CLEAR),
            .slow_tick (slow_tick),
            .alt_tick  (alt_tick),
            .cnt_o     (cnt_w),
            .load_o    (load_w),
            .ctrl_o    (ctrl_rd[i]),
            .irq_o     (irq[i])
        );

        assign cnt_ext[i]  = DATA_W'(cnt_w);
        assign load_ext[i] = DATA_W'(load_w);
    end

    tmr_freerun #(.WIDTH(FREE_W)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_wr     (wr_stb && bus_addr == FREE_HI_ADDR),
        .en_val    (bus_wdata[FREE_EN_BIT]),
        .fast_tick (fast_tick),
        .cnt_o     (free_cnt),
        .en_o      (free_en)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            for (int k = 0; k < NUM_RELOAD; k++) begin
                if (bus_addr == chan_base(k) + OFS_LOAD)  bus_rdata = load_ext[k];
                if (bus_addr == chan_base(k) + OFS_COUNT) bus_rdata = cnt_ext[k];
                if (bus_addr == chan_base(k) + OFS_CTRL)  bus_rdata = DATA_W'(ctrl_rd[k]);
            end
            if (bus_addr == FREE_LO_ADDR) bus_rdata = free_cnt[DATA_W-1:0];
            if (bus_addr == FREE_HI_ADDR) begin
                bus_rdata[HI_W-1:0]   = free_cnt[FREE_W-1:DATA_W];
                bus_rdata[FREE_EN_BIT] = free_en;
            end
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (irq == 3'b000 && free_cnt == '0));

endmodule

// File: tb/tick_timer_bank_test.sv
module tick_timer_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        slow_tick = 1'b0, alt_tick = 1'b0, fast_tick = 1'b0;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;
    bit rd_valid = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] mask;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #2 clk = ~clk;

    tick_timer_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .slow_tick(slow_tick), .alt_tick(alt_tick), .fast_tick(fast_tick),
        .irq(irq)
    );

    // monitor: pops expectations and compares mid low phase
    always @(negedge clk) begin
        #1;
        if (rd_valid && sbq.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sbq.pop_front();
            act = it.is_irq ? {29'b0, irq} : bus_rdata;
            checks++;
            if ((act & it.mask) !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.tag, act & it.mask, it.exp);
            end
        end
    end

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it = '{is_irq: 1'b0, mask: 32'hFFFF_FFFF, exp: e, tag: tag};
        sbq.push_back(it);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic expect_irq(input logic [2:0] m, input logic [2:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it = '{is_irq: 1'b1, mask: {29'b0, m}, exp: {29'b0, e}, tag: tag};
        sbq.push_back(it);
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    // which: 0 slow, 1 alt, 2 fast
    task automatic pulse(input int which, input int n);
        for (int p = 0; p < n; p++) begin
            @(negedge clk);
            case (which)
                0: slow_tick = 1'b1;
                1: alt_tick  = 1'b1;
                default: fast_tick = 1'b1;
            endcase
            @(negedge clk);
            slow_tick = 1'b0; alt_tick = 1'b0; fast_tick = 1'b0;
        end
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_reg(8'h00, 32'h0, "R1 load0");
        expect_reg(8'h04, 32'h0, "R1 cnt0");
        expect_reg(8'h08, 32'h0, "R1 ctrl0");
        expect_reg(8'h84, 32'h0, "R1 cnt2");
        expect_reg(8'h60, 32'h0, "R1 free lo");
        expect_reg(8'h64, 32'h0, "R1 free hi");
        expect_irq(3'b111, 3'b000, "R1 irq");

        // R2 widths and map, R8 load sets count
        reg_wr(8'h00, 32'h0001_2345);
        expect_reg(8'h00, 32'h0000_2345, "R2 load truncated");
        expect_reg(8'h04, 32'h0000_2345, "R8 count follows load");
        reg_wr(8'h80, 32'h89AB_CDEF);
        expect_reg(8'h84, 32'h89AB_CDEF, "R2 32-bit channel");

        // R3 stopped channel holds, R9 readback
        reg_wr(8'h08, 32'h48);
        pulse(0, 3);
        expect_reg(8'h04, 32'h0000_2345, "R3 stopped holds");
        expect_reg(8'h08, 32'h48, "R9 ctrl readback");
        reg_wr(8'h28, 32'hFF);
        expect_reg(8'h28, 32'hC8, "R9 masked bits");
        reg_wr(8'h28, 32'h00);
        expect_reg(8'h28, 32'h00, "R9 stop readback");

        // R3 R4 R6 R7 periodic on slow tick
        reg_wr(8'h00, 32'd3);
        reg_wr(8'h08, 32'hC8);
        pulse(0, 1);
        expect_reg(8'h04, 32'd2, "R3 decrement");
        pulse(1, 2);
        expect_reg(8'h04, 32'd2, "R7 alt ignored");
        pulse(0, 2);
        expect_reg(8'h04, 32'd0, "R4 reached zero");
        expect_irq(3'b001, 3'b000, "R6 no irq before underflow");
        pulse(0, 1);
        expect_reg(8'h04, 32'd3, "R4 reload");
        expect_irq(3'b001, 3'b001, "R6 irq on underflow");
        pulse(0, 4);
        expect_reg(8'h04, 32'd3, "R4 period load+1");
        expect_irq(3'b001, 3'b001, "R6 irq held");
        reg_wr(8'h0C, 32'h0);
        expect_irq(3'b001, 3'b000, "R6 clear");
        expect_reg(8'h04, 32'd3, "R6 clear keeps count");

        // R5 free mode wrap
        reg_wr(8'h20, 32'd1);
        reg_wr(8'h28, 32'h88);
        pulse(0, 2);
        expect_reg(8'h24, 32'h0000_FFFF, "R5 wrap 16-bit");
        expect_irq(3'b010, 3'b010, "R6 irq channel 1");
        reg_wr(8'h2C, 32'hFFFF_FFFF);
        expect_irq(3'b010, 3'b000, "R6 clear channel 1");

        // R7 alternate source on channel 2
        reg_wr(8'h80, 32'd2);
        reg_wr(8'h88, 32'h80);
        pulse(0, 2);
        expect_reg(8'h84, 32'd2, "R7 slow ignored when alt selected");
        pulse(1, 1);
        expect_reg(8'h84, 32'd1, "R7 alt counts");
        pulse(1, 2);
        expect_reg(8'h84, 32'hFFFF_FFFF, "R5 wrap 32-bit");
        expect_irq(3'b100, 3'b100, "R6 irq channel 2");

        // R8 restart while running
        reg_wr(8'h00, 32'h10);
        expect_reg(8'h04, 32'h10, "R8 restart running");
        pulse(0, 1);
        expect_reg(8'h04, 32'h0F, "R8 counts from new value");

        // R10 free-running counter
        pulse(2, 3);
        expect_reg(8'h60, 32'h0, "R10 disabled holds");
        reg_wr(8'h64, 32'h100);
        expect_reg(8'h64, 32'h100, "R10 enable readback");
        pulse(2, 5);
        expect_reg(8'h60, 32'd5, "R10 counts fast ticks");
        reg_wr(8'h60, 32'hDEAD);
        expect_reg(8'h60, 32'd5, "R10 low write ignored");
        reg_wr(8'h64, 32'h0);
        pulse(2, 2);
        expect_reg(8'h60, 32'd5, "R10 disable holds");
        expect_reg(8'h64, 32'h0, "R10 disable readback");

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule